// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block times how quickly a person reacts to a visual cue. A press of the start button begins a trial, and the display is set to zero at once. The block then waits a pseudo-random number of millisecond ticks. That number is drawn from a free-running linear feedback shift register at the moment of the press. When the wait ends, the block drives the stimulus output high and counts ticks until the response button is pressed. The count is the trial result. It is kept in a holding slot and shown on the four-digit BCD display. If the response button is pressed before the cue appears, the attempt is a false start: the display shows 9999 and nothing is stored.

After eight stored results, the block sums all eight slots in an accumulator. It forms the mean by dropping the three low bits of the sum, so no divider is needed. It then converts the mean to BCD, shows it, and pulses a done flag. A sequential shift-and-add-three converter turns every binary value into BCD before it reaches the display. The button inputs are expected to be debounced already and are acted on at their rising edges. The tick input is a one-cycle pulse once per millisecond. The display output is a plain held value with no handshake, because the seven-segment scanner samples it continuously.

Top module: `reaction_timer`

## Requirements
- R1: A rising edge on start_i, accepted in idle while no BCD conversion is running, sets disp_o to 0x0000 and holds stim_o low from the next cycle on.
- R2: stim_o rises on the W-th tick after the accepted start, where W lies in [MIN_WAIT, MIN_WAIT+WAIT_SPAN-1] (1000 to 9999 by default) and is derived from the shift register value at the start edge.
- R3: The trial result equals the number of ticks seen while stim_o is high before the rising edge of resp_i. stim_o falls in the cycle after that edge.
- R4: The reaction count saturates at MAX_MS (9999), so a late response records and shows 9999.
- R5: A rising edge on resp_i while waiting for the cue is a false start. The cue never appears, disp_o shows 0x9999, the block returns to idle, and the attempt is not counted.
- R6: disp_o carries each value as four BCD digits: bits 3:0 are the ones, 7:4 the tens, 11:8 the hundreds and 15:12 the thousands. No digit exceeds 9.
- R7: After the eighth stored trial, done_o is high for exactly one cycle. In that cycle disp_o shows floor(sum of the eight results / 8) in BCD.
- R8: The trial count restarts after the mean is produced, so the next eight trials give an independent mean.
- R9: A start edge outside idle, or while a conversion is running, is ignored. A response edge in idle is ignored. Neither changes stim_o or disp_o.
- R10: While rst_n is low, stim_o and done_o are 0 and disp_o is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Debounced start button; acts on its rising edge |
| resp_i | input | 1 | Debounced response button; acts on its rising edge |
| tick_i | input | 1 | One-cycle pulse each millisecond |
| stim_o | output | 1 | Stimulus lamp, high while the reaction is being timed |
| disp_o | output | 4*DIGITS | BCD value for the display, ones digit lowest |
| done_o | output | 1 | One-cycle pulse when the mean is on the display |

## Verification
The bound checker watches, on every cycle, the properties that follow from a single event. An accepted start clears the display. A response drops the cue, and an early response sends the block back to idle. The reaction count never passes 9999, every display digit is a valid decimal, the mean never exceeds 9999, and done never lasts two cycles. Other behaviours span whole trials and can only be shown by the bench's scenarios: the wait length falling inside its window, the exact tick count of each result, the arithmetic of the eight-trial mean, and the restart of the trial count. The same holds for the ignored presses, where the bench confirms that no cue appears for longer than any legal wait.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_STIM = 3'd2,
    ST_REC  = 3'd3,
    ST_SUM  = 3'd4,
    ST_CONV = 3'd5
  } rt_state_e;

endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int unsigned         W    = 16,
  parameter logic [W-1:0]        TAPS = 16'hB400,
  parameter logic [W-1:0]        SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value_o
);

  logic [W-1:0] state_q;

  // Galois form, shifting right; the seed must be non-zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign value_o = state_q;

endmodule

// File: rtl/rt_bin2bcd.sv
module rt_bin2bcd #(
  parameter int unsigned BIN_W  = 14,
  parameter int unsigned DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [BIN_W-1:0]      bin_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [4*DIGITS-1:0]   bcd_o
);

  localparam int unsigned BCD_W = 4 * DIGITS;
  localparam int unsigned SH_W  = BCD_W + BIN_W;
  localparam int unsigned CNT_W = $clog2(BIN_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  adj;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  // add three to every digit of five or more before each shift
  assign adj[BIN_W-1:0] = sh_q[BIN_W-1:0];
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] dig;
    assign dig = sh_q[BIN_W + 4*d +: 4];
    assign adj[BIN_W + 4*d +: 4] = (dig >= 4'd5) ? dig + 4'd3 : dig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        sh_q  <= {adj[SH_W-2:0], 1'b0};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (go_i) begin
        sh_q   <= {{BCD_W{1'b0}}, bin_i};
        cnt_q  <= CNT_W'(BIN_W);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign bcd_o  = sh_q[SH_W-1:BIN_W];

endmodule

// File: rtl/rt_result_bank.sv
module rt_result_bank #(
  parameter int unsigned LOG2 = 3,
  parameter int unsigned MS_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [LOG2-1:0]   wr_idx_i,
  input  logic [MS_W-1:0]   wr_data_i,
  input  logic              sum_go_i,
  output logic              sum_fin_o,
  output logic [MS_W-1:0]   avg_o
);

  localparam int unsigned TRIALS = 1 << LOG2;
  localparam int unsigned ACC_W  = MS_W + LOG2;
  localparam logic [LOG2-1:0] LAST = '1;

  logic [MS_W-1:0]  hold_q [TRIALS];
  logic [ACC_W-1:0] acc_q;
  logic [LOG2-1:0]  ptr_q;
  logic             run_q;
  logic             fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TRIALS; i++) hold_q[i] <= '0;
      acc_q <= '0;
      ptr_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (wr_en_i) hold_q[wr_idx_i] <= wr_data_i;
      if (sum_go_i) begin
        acc_q <= '0;
        ptr_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_q + ACC_W'(hold_q[ptr_q]);
        ptr_q <= ptr_q + LOG2'(1);
        if (ptr_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign sum_fin_o = fin_q;
  // dividing by a power of two: drop the low LOG2 bits
  assign avg_o     = acc_q[ACC_W-1:LOG2];

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int unsigned MAX_MS     = 9999,
  parameter int unsigned MIN_WAIT   = 1000,
  parameter int unsigned WAIT_SPAN  = 9000,
  parameter int unsigned TRIAL_LOG2 = 3,
  parameter int unsigned LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int unsigned DIGITS     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  resp_i,
  input  logic                  tick_i,
  output logic                  stim_o,
  output logic [4*DIGITS-1:0]   disp_o,
  output logic                  done_o
);

  localparam int unsigned MS_W   = $clog2(MAX_MS + 1);
  localparam int unsigned WAIT_W = $clog2(MIN_WAIT + WAIT_SPAN);
  localparam int unsigned BCD_W  = 4 * DIGITS;
  localparam logic [MS_W-1:0]       MS_MAX   = MS_W'(MAX_MS);
  localparam logic [TRIAL_LOG2-1:0] IDX_LAST = '1;

  rt_state_e             state_q;
  logic                  start_q, resp_q;
  logic                  start_pe, resp_pe;
  logic [WAIT_W-1:0]     wcnt_q;
  logic [WAIT_W-1:0]     wait_ld;
  logic [MS_W-1:0]       rt_q;
  logic [TRIAL_LOG2-1:0] idx_q;
  logic [BCD_W-1:0]      disp_q;
  logic                  done_q;
  logic                  conv_avg_q;

  logic [LFSR_W-1:0]     rnd;
  logic [LFSR_W-1:0]     rnd_rem;
  logic                  conv_go, conv_busy, conv_done;
  logic [MS_W-1:0]       conv_val;
  logic [BCD_W-1:0]      conv_bcd;
  logic                  bank_wr, sum_go, bank_fin;
  logic [MS_W-1:0]       bank_avg;

  assign start_pe = start_i & ~start_q;
  assign resp_pe  = resp_i & ~resp_q;

  rt_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .value_o (rnd)
  );

  // map the random word onto the wait window
  assign rnd_rem = rnd % LFSR_W'(WAIT_SPAN);
  assign wait_ld = WAIT_W'(MIN_WAIT) + WAIT_W'(rnd_rem);

  rt_bin2bcd #(
    .BIN_W  (MS_W),
    .DIGITS (DIGITS)
  ) u_conv (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (conv_go),
    .bin_i  (conv_val),
    .busy_o (conv_busy),
    .done_o (conv_done),
    .bcd_o  (conv_bcd)
  );

  rt_result_bank #(
    .LOG2 (TRIAL_LOG2),
    .MS_W (MS_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (bank_wr),
    .wr_idx_i  (idx_q),
    .wr_data_i (rt_q),
    .sum_go_i  (sum_go),
    .sum_fin_o (bank_fin),
    .avg_o     (bank_avg)
  );

  always_comb begin
    conv_go  = 1'b0;
    conv_val = rt_q;
    bank_wr  = 1'b0;
    sum_go   = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (resp_pe) begin
          conv_go  = 1'b1;
          conv_val = MS_MAX;
        end
      end
      ST_REC: begin
        conv_go = 1'b1;
        bank_wr = 1'b1;
        sum_go  = (idx_q == IDX_LAST);
      end
      ST_CONV: begin
        if (!conv_busy) begin
          conv_go  = 1'b1;
          conv_val = bank_avg;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      start_q    <= 1'b0;
      resp_q     <= 1'b0;
      wcnt_q     <= '0;
      rt_q       <= '0;
      idx_q      <= '0;
      disp_q     <= '0;
      done_q     <= 1'b0;
      conv_avg_q <= 1'b0;
    end else begin
      start_q <= start_i;
      resp_q  <= resp_i;
      done_q  <= 1'b0;

      if (conv_done) begin
        disp_q     <= conv_bcd;
        done_q     <= conv_avg_q;
        conv_avg_q <= 1'b0;
      end

      case (state_q)
        ST_IDLE: begin
          if (start_pe && !conv_busy) begin
            disp_q  <= '0;
            wcnt_q  <= wait_ld;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (resp_pe) begin
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            if (wcnt_q == WAIT_W'(1)) begin
              rt_q    <= '0;
              state_q <= ST_STIM;
            end else begin
              wcnt_q <= wcnt_q - WAIT_W'(1);
            end
          end
        end
        ST_STIM: begin
          if (resp_pe) begin
            state_q <= ST_REC;
          end else if (tick_i && rt_q != MS_MAX) begin
            rt_q <= rt_q + MS_W'(1);
          end
        end
        ST_REC: begin
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            state_q <= ST_SUM;
          end else begin
            idx_q   <= idx_q + TRIAL_LOG2'(1);
            state_q <= ST_IDLE;
          end
        end
        ST_SUM: begin
          if (bank_fin) state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (!conv_busy) begin
            conv_avg_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stim_o = (state_q == ST_STIM);
  assign disp_o = disp_q;
  assign done_o = done_q;

endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
#(
  parameter int unsigned MAX_MS = 9999,
  parameter int unsigned MS_W   = 14,
  parameter int unsigned BCD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pe,
  input  logic              resp_pe,
  input  logic              conv_busy,
  input  rt_state_e         state,
  input  logic              stim_o,
  input  logic [BCD_W-1:0]  disp_o,
  input  logic              done_o,
  input  logic [MS_W-1:0]   rt_cnt,
  input  logic              bank_fin,
  input  logic [MS_W-1:0]   bank_avg
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_pe && !conv_busy) |=> (disp_o == '0 && !stim_o)); // R1

  AST_RESP_DROPS_STIM: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_o && resp_pe) |=> !stim_o); // R3

  AST_RT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    rt_cnt <= MS_W'(MAX_MS)); // R4

  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && resp_pe) |=> (state == ST_IDLE && !stim_o)); // R5

  for (genvar d = 0; d < BCD_W / 4; d++) begin : g_dig
    AST_BCD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      disp_o[4*d +: 4] <= 4'd9); // R6
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_AVG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_fin |-> bank_avg <= MS_W'(MAX_MS)); // R7

endmodule

bind reaction_timer rt_checker #(
  .MAX_MS (MAX_MS),
  .MS_W   (MS_W),
  .BCD_W  (BCD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_pe  (start_pe),
  .resp_pe   (resp_pe),
  .conv_busy (conv_busy),
  .state     (state_q),
  .stim_o    (stim_o),
  .disp_o    (disp_o),
  .done_o    (done_o),
  .rt_cnt    (rt_q),
  .bank_fin  (bank_fin),
  .bank_avg  (bank_avg)
);

// File: tb/tb_reaction_timer.sv
module tb_reaction_timer;

  localparam int MAX_MS = 9999;
  localparam int MIN_W  = 100;
  localparam int SPAN   = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        resp_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        stim_o;
  logic        done_o;
  logic [15:0] disp_o;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int done_cnt = 0;
  int round_sum = 0;
  logic [15:0] done_disp = '0;

  always #10 clk = ~clk;

  reaction_timer #(
    .MIN_WAIT  (MIN_W),
    .WAIT_SPAN (SPAN)
  ) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .resp_i  (resp_i),
    .tick_i  (tick_i),
    .stim_o  (stim_o),
    .disp_o  (disp_o),
    .done_o  (done_o)
  );

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      done_cnt  = done_cnt + 1;
      done_disp = disp_o;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [15:0] bcd4(int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nvec = nvec + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive inputs just after a falling edge, then move to the next one
  task automatic step(bit t, bit s, bit r);
    tick_i  = t;
    start_i = s;
    resp_i  = r;
    @(negedge clk);
  endtask

  task automatic wait_stim(output int cnt);
    int ph = 0;
    int guard = 0;
    cnt = 0;
    while (!stim_o && guard < 5000) begin
      step(ph == 2, 1'b0, 1'b0);
      if (ph == 2) cnt++;
      ph = (ph + 1) % 3;
      guard++;
    end
  endtask

  task automatic no_stim_window(string req, string what);
    bit seen = 1'b0;
    for (int k = 0; k < MIN_W + SPAN + 10; k++) begin
      step(1'b1, 1'b0, 1'b0);
      if (stim_o) seen = 1'b1;
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
    check(!seen, req, what, int'(seen), 0);
  endtask

  task automatic trial(int n, bit mid_start, bit busy_start, bit last);
    int w;
    int expv;
    expv = (n > MAX_MS) ? MAX_MS : n;
    step(1'b0, 1'b1, 1'b0);
    check(disp_o == 16'h0000 && !stim_o, "R1", "display cleared on start", int'(disp_o), 0);
    wait_stim(w);
    check(w >= MIN_W && w <= MIN_W + SPAN - 1, "R2", "ticks before stimulus", w, MIN_W);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      if (mid_start && k == n / 2) begin
        step(1'b0, 1'b1, 1'b0);
        check(stim_o == 1'b1, "R9", "start during stimulus ignored", int'(stim_o), 1);
      end else begin
        step(1'b0, 1'b0, 1'b0);
      end
    end
    step(1'b0, 1'b0, 1'b1);
    check(!stim_o, "R3", "stimulus drops after response", int'(stim_o), 0);
    round_sum += expv;
    if (busy_start) begin
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      no_stim_window("R9", "start during conversion ignored");
      check(disp_o == bcd4(expv), "R6", "result digits", int'(disp_o), int'(bcd4(expv)));
    end else if (!last) begin
      repeat (30) step(1'b0, 1'b0, 1'b0);
      check(disp_o == bcd4(expv), (n > MAX_MS) ? "R4" : "R3", "result shown",
            int'(disp_o), int'(bcd4(expv)));
    end else begin
      repeat (80) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic false_start();
    step(1'b0, 1'b1, 1'b0);
    repeat (5) begin
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
    step(1'b0, 1'b0, 1'b1);
    check(!stim_o, "R5", "no stimulus on false start", int'(stim_o), 0);
    repeat (30) step(1'b0, 1'b0, 1'b0);
    check(disp_o == 16'h9999, "R5", "false start display", int'(disp_o), 16'h9999);
    no_stim_window("R5", "idle after false start");
  endtask

  task automatic round(bit first);
    int n;
    round_sum = 0;
    done_cnt  = 0;
    for (int i = 0; i < 8; i++) begin
      n = int'($urandom_range(400, 0));
      if (first && i == 1) n = 50 + int'($urandom_range(100, 0));
      if (first && i == 2) n = 10050;
      if (first && i == 5) n = 0;
      if (!first && i == 3) n = 1;
      if (first && i == 3) false_start();
      trial(n, first && i == 1, first && i == 6, i == 7);
      if (first && i == 4) begin
        logic [15:0] held;
        held = disp_o;
        step(1'b0, 1'b0, 1'b1);
        repeat (30) step(1'b0, 1'b0, 1'b0);
        check(disp_o == held && !stim_o, "R9", "response in idle ignored",
              int'(disp_o), int'(held));
      end
      if (i < 7) check(done_cnt == 0, first ? "R7" : "R8", "no done before eighth trial", done_cnt, 0);
    end
    repeat (2) step(1'b0, 1'b0, 1'b0);
    check(done_cnt == 1, first ? "R7" : "R8", "single done pulse", done_cnt, 1);
    check(done_disp == bcd4(round_sum / 8), first ? "R7" : "R8", "mean at done",
          int'(done_disp), int'(bcd4(round_sum / 8)));
    check(disp_o == bcd4(round_sum / 8), "R6", "mean held on display",
          int'(disp_o), int'(bcd4(round_sum / 8)));
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check(!stim_o && !done_o && disp_o == 16'h0000, "R10", "outputs in reset", int'(disp_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stim_o && !done_o && disp_o == 16'h0000, "R10", "outputs after reset", int'(disp_o), 0);
    round(1'b1);
    round(1'b0);
    summary();
    $finish;
  end

endmodule